// File: doc/BRIEF.md
# Strided 2D DMA Address Generator

This block sequences the word addresses of a single DMA channel. Once started, it walks a two-dimensional buffer of 32-bit words. Each line has a configured number of words. The first word of each line lies a configured pitch (in words) beyond the first word of the line before it. The frame has a configured number of lines. The data mover raises a one-cycle advance strobe each time it consumes the word at the current address. The generator then steps to the next address, and it pulses a done flag after the last word of the frame.

A line length of zero selects a circular ping-pong mode instead. The region covered is pitch × (line-count field + 1) words. It is walked linearly and wraps back to its start after its last word. A half-buffer event is pulsed each time the walk completes the first half of the region, and again each time it completes the second half. An accompanying flag tells which half has just finished. The walk continues until the loop enable is removed. Software can read the current address at any time and compute the remaining byte count from the start address.

All addresses are word addresses: a byte address must be shifted right by two before it is loaded.

Top module: `stride2d_agen`

## Requirements
- R1: After reset, busy, done and half_evt are 0 and addr is 0.
- R2: A start pulse while idle latches the configuration. On the next cycle busy is 1 and addr equals start_addr.
- R3: Within a line, each accepted advance strobe raises addr by exactly one word. Without an advance strobe, addr holds its value.
- R4: After the last word of a line (line_len words), addr becomes the first word of that line plus pitch.
- R5: The line-count field holds the number of lines minus one. A value of 0 gives a frame of exactly one line.
- R6: In grid mode (line_len ≠ 0), accepting the last word of the last line gives a done pulse one cycle wide. The pulse falls in the cycle in which busy drops, and addr keeps the last word's address.
- R7: line_len = 0 selects loop mode. The region is pitch × (line_cnt + 1) words. After its last word, addr returns to start_addr, and done is never raised.
- R8: In loop mode, with an even region size, half_evt pulses one cycle after the word at offset region/2 − 1 is accepted, with half_sel = 0. It pulses again one cycle after the word at offset region − 1 is accepted, with half_sel = 1. half_evt is never high together with done.
- R9: In loop mode, an advance strobe accepted while loop_en is 0 consumes that word. busy then drops on the next cycle, without a done pulse.
- R10: A start pulse while busy is ignored and the walk continues unchanged. An advance strobe while idle is ignored: addr is unchanged and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk with the configuration inputs (idle only) |
| start_addr | input | AW | First word address of the buffer |
| line_len | input | LW | Words per line; 0 selects loop mode |
| pitch | input | LW | Word distance between the starts of consecutive lines |
| line_cnt | input | YW | Number of lines minus one |
| loop_en | input | 1 | Keeps loop mode running; when low, the walk stops at the next accepted word |
| adv | input | 1 | The word at addr has been consumed |
| busy | output | 1 | A walk is in progress |
| addr | output | AW | Current word address |
| done | output | 1 | One-cycle pulse at the end of a grid-mode frame |
| half_evt | output | 1 | One-cycle pulse when a half of the loop region completes |
| half_sel | output | 1 | 0 = first half completed, 1 = second half completed (valid with half_evt) |

## Verification
The hardest cases to reach from the ports are the loop-mode boundaries. In one, the wrap to the start address coincides with the second-half event. In the other, the stop request lands on the very word that closes a half. The stimulus runs the loop through several complete laps of a small region, so that both halves fire more than once. It then drops loop_en just before the accepted word that ends a half. A start pulse is also injected in the middle of a grid walk that has irregular gaps between advance strobes. A predicted address list is kept per word, so any corruption of the latched configuration shows up as a wrong address.

// File: rtl/s2d_pkg.sv
package s2d_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_GRID = 2'd1,
        MODE_RING = 2'd2
    } mode_e;
endpackage

// File: rtl/s2d_step.sv
module s2d_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] last,
    output logic [W-1:0] nxt,
    output logic         at_last
);
    always_comb begin
        at_last = (cur == last);
        nxt     = at_last ? '0 : cur + W'(1);
    end
endmodule

// File: rtl/s2d_region_calc.sv
module s2d_region_calc #(
    parameter int LW = 16,
    parameter int YW = 16,
    parameter int RW = LW + YW
) (
    input  logic [LW-1:0] pitch,
    input  logic [YW-1:0] line_cnt,
    output logic [RW-1:0] region_last,
    output logic [RW-1:0] half_last
);
    logic [RW-1:0] lines_w;
    logic [RW-1:0] region_w;

    always_comb begin
        lines_w     = RW'(line_cnt) + RW'(1);
        region_w    = RW'(pitch) * lines_w;
        region_last = region_w - RW'(1);
        half_last   = (region_w >> 1) - RW'(1);
    end
endmodule

// File: rtl/stride2d_agen.sv
module stride2d_agen
    import s2d_pkg::*;
#(
    parameter int AW = 30,
    parameter int LW = 16,
    parameter int YW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [LW-1:0] line_len,
    input  logic [LW-1:0] pitch,
    input  logic [YW-1:0] line_cnt,
    input  logic          loop_en,
    input  logic          adv,
    output logic          busy,
    output logic [AW-1:0] addr,
    output logic          done,
    output logic          half_evt,
    output logic          half_sel
);
    localparam int RW = LW + YW;

    typedef struct packed {
        mode_e         mode;
        logic [AW-1:0] base;
        logic [AW-1:0] addr;
        logic [AW-1:0] line_base;
        logic [LW-1:0] x;
        logic [LW-1:0] x_last;
        logic [LW-1:0] pitch;
        logic [YW-1:0] y;
        logic [YW-1:0] y_last;
        logic [RW-1:0] ofs;
        logic [RW-1:0] reg_last;
        logic [RW-1:0] half_last;
        logic          done;
        logic          half;
        logic          half_sel;
    } st_t;

    st_t st_d, st_q;

    logic [RW-1:0] reg_last_w, half_last_w;
    logic [LW-1:0] x_nxt;
    logic [YW-1:0] y_nxt;
    logic [RW-1:0] ofs_nxt;
    logic          x_end, y_end, ofs_end;

    s2d_region_calc #(.LW(LW), .YW(YW), .RW(RW)) region_i (
        .pitch       (pitch),
        .line_cnt    (line_cnt),
        .region_last (reg_last_w),
        .half_last   (half_last_w)
    );

    s2d_step #(.W(LW)) x_step_i (
        .cur (st_q.x), .last (st_q.x_last), .nxt (x_nxt), .at_last (x_end)
    );

    s2d_step #(.W(YW)) y_step_i (
        .cur (st_q.y), .last (st_q.y_last), .nxt (y_nxt), .at_last (y_end)
    );

    s2d_step #(.W(RW)) ofs_step_i (
        .cur (st_q.ofs), .last (st_q.reg_last), .nxt (ofs_nxt), .at_last (ofs_end)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.half = 1'b0;
        unique case (st_q.mode)
            MODE_IDLE: begin
                if (start) begin
                    st_d.base      = start_addr;
                    st_d.addr      = start_addr;
                    st_d.line_base = start_addr;
                    st_d.x         = '0;
                    st_d.y         = '0;
                    st_d.ofs       = '0;
                    st_d.pitch     = pitch;
                    st_d.x_last    = line_len - LW'(1);
                    st_d.y_last    = line_cnt;
                    st_d.reg_last  = reg_last_w;
                    st_d.half_last = half_last_w;
                    st_d.mode      = (line_len == '0) ? MODE_RING : MODE_GRID;
                end
            end
            MODE_GRID: begin
                if (adv) begin
                    if (x_end) begin
                        if (y_end) begin
                            st_d.mode = MODE_IDLE;
                            st_d.done = 1'b1;
                        end else begin
                            st_d.line_base = st_q.line_base + AW'(st_q.pitch);
                            st_d.addr      = st_q.line_base + AW'(st_q.pitch);
                            st_d.x         = x_nxt;
                            st_d.y         = y_nxt;
                        end
                    end else begin
                        st_d.addr = st_q.addr + AW'(1);
                        st_d.x    = x_nxt;
                    end
                end
            end
            MODE_RING: begin
                if (adv) begin
                    st_d.ofs  = ofs_nxt;
                    st_d.addr = ofs_end ? st_q.base : st_q.addr + AW'(1);
                    if (ofs_end) begin
                        st_d.half     = 1'b1;
                        st_d.half_sel = 1'b1;
                    end else if (st_q.ofs == st_q.half_last) begin
                        st_d.half     = 1'b1;
                        st_d.half_sel = 1'b0;
                    end
                    if (!loop_en) begin
                        st_d.mode = MODE_IDLE;
                    end
                end
            end
            default: st_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.mode != MODE_IDLE);
    assign addr     = st_q.addr;
    assign done     = st_q.done;
    assign half_evt = st_q.half;
    assign half_sel = st_q.half_sel;
endmodule

// File: rtl/stride2d_agen_chk.sv
module stride2d_agen_chk #(
    parameter int AW = 30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] start_addr,
    input logic          adv,
    input logic          busy,
    input logic [AW-1:0] addr,
    input logic          done,
    input logic          half_evt
);
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && (addr == $past(start_addr)));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !adv |=> $stable(addr));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_half_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        half_evt |-> !done);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> !busy && $stable(addr) && !done);
endmodule

bind stride2d_agen stride2d_agen_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .adv        (adv),
    .busy       (busy),
    .addr       (addr),
    .done       (done),
    .half_evt   (half_evt)
);

// File: tb/stride2d_agen_tb_top.sv
module stride2d_agen_tb_top;
    localparam int AW = 30;
    localparam int LW = 16;
    localparam int YW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] line_len = '0;
    logic [LW-1:0] pitch = '0;
    logic [YW-1:0] line_cnt = '0;
    logic          loop_en = 1'b0;
    logic          adv = 1'b0;
    logic          busy, done, half_evt, half_sel;
    logic [AW-1:0] addr;

    always #5 clk = ~clk;

    stride2d_agen #(.AW(AW), .LW(LW), .YW(YW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .line_len(line_len), .pitch(pitch), .line_cnt(line_cnt),
        .loop_en(loop_en), .adv(adv), .busy(busy), .addr(addr),
        .done(done), .half_evt(half_evt), .half_sel(half_sel)
    );

    typedef struct {
        longint a;
        bit     dn;
        bit     hf;
        bit     hs;
        string  rq;
    } exp_t;

    exp_t q[$];
    exp_t pend_item;
    bit   pend = 0;
    int   total = 0;
    int   bad = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // monitor: compares each consumed word and the flags that follow it
    always @(negedge clk) begin
        if (pend) begin
            check(done == pend_item.dn, pend_item.rq, "done", done, pend_item.dn);
            check(half_evt == pend_item.hf, "R8", "half_evt", half_evt, pend_item.hf);
            if (pend_item.hf)
                check(half_sel == pend_item.hs, "R8", "half_sel", half_sel, pend_item.hs);
            pend = 0;
        end
        if (rst_n && adv && busy) begin
            if (q.size() == 0) begin
                check(0, "R3", "unexpected word", addr, -1);
            end else begin
                pend_item = q.pop_front();
                check(addr == AW'(pend_item.a), pend_item.rq, "addr", addr, pend_item.a);
                pend = 1;
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic advance(input int gap);
        adv = 1'b1;
        step();
        adv = 1'b0;
        repeat (gap) step();
    endtask

    task automatic kick(input longint sa, input int ll, input int pt, input int lc);
        start_addr = AW'(sa);
        line_len   = LW'(ll);
        pitch      = LW'(pt);
        line_cnt   = YW'(lc);
        start      = 1'b1;
        step();
        start      = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
        check(addr == AW'(sa), "R2", "addr after start", addr, sa);
    endtask

    task automatic run_grid(input longint sa, input int ll, input int pt, input int lc,
                            input int gap, input bit poke, input string rq);
        int n = 0;
        longint last_a = 0;
        kick(sa, ll, pt, lc);
        for (int y = 0; y <= lc; y++) begin
            for (int x = 0; x < ll; x++) begin
                exp_t e;
                e.a  = sa + longint'(y) * pt + x;
                e.dn = (y == lc) && (x == ll - 1);
                e.hf = 0;
                e.hs = 0;
                e.rq = (x == 0 && y > 0) ? "R4" : rq;
                last_a = e.a;
                q.push_back(e);
                n++;
            end
        end
        for (int k = 0; k < n; k++) begin
            if (poke && k == n / 2) begin
                // R10: start while busy must be ignored
                start_addr = AW'(999);
                line_len   = LW'(7);
                pitch      = LW'(1);
                start      = 1'b1;
                step();
                start      = 1'b0;
            end
            advance(gap);
        end
        step();
        check(busy == 1'b0, "R6", "busy after frame", busy, 0);
        check(addr == AW'(last_a), "R6", "addr holds last word", addr, last_a);
        check(q.size() == 0, rq, "words left over", q.size(), 0);
    endtask

    task automatic run_ring(input longint sa, input int pt, input int lc, input int nwords);
        int region = pt * (lc + 1);
        int half = region / 2;
        loop_en = 1'b1;
        kick(sa, 0, pt, lc);
        for (int k = 0; k < nwords; k++) begin
            exp_t e;
            int o = k % region;
            e.a  = sa + o;
            e.dn = 0;
            e.hf = (o == half - 1) || (o == region - 1);
            e.hs = (o == region - 1);
            e.rq = (o == 0 && k > 0) ? "R7" : "R9";
            q.push_back(e);
        end
        for (int k = 0; k < nwords; k++) begin
            if (k == nwords - 1) loop_en = 1'b0;
            advance(k % 3 == 1 ? 1 : 0);
        end
        step();
        check(busy == 1'b0, "R9", "busy after stop", busy, 0);
        check(q.size() == 0, "R7", "words left over", q.size(), 0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        check(0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check(busy == 1'b0, "R1", "busy", busy, 0);
        check(addr == '0, "R1", "addr", addr, 0);
        check(done == 1'b0, "R1", "done", done, 0);
        check(half_evt == 1'b0, "R1", "half_evt", half_evt, 0);

        // R3/R4/R6: 3 words per line, pitch 5, 3 lines, back-to-back strobes
        run_grid(100, 3, 5, 2, 0, 0, "R3");
        // R5: single line, single word
        run_grid(200, 1, 9, 0, 0, 0, "R5");
        // R5: single line of several words with gaps
        run_grid(250, 4, 4, 0, 2, 0, "R5");
        // R3/R4 with gaps and R10 start injection mid-walk
        run_grid(1000, 2, 16, 3, 1, 1, "R10");

        // R10: advance while idle ignored
        begin
            logic [AW-1:0] held;
            held = addr;
            for (int i = 0; i < 3; i++) begin
                advance(0);
                check(addr == held, "R10", "addr while idle", addr, held);
                check(done == 1'b0, "R10", "done while idle", done, 0);
                check(busy == 1'b0, "R10", "busy while idle", busy, 0);
            end
        end

        // R7/R8/R9: region 2*4=8 words, 2.5 laps, stop on a first-half end
        run_ring(300, 2, 3, 20);
        // R8/R9: region 6 words, stop on the wrap word
        run_ring(5000, 3, 1, 12);

        repeat (3) step();
        finish_run();
    end
endmodule